// File: doc/BRIEF.md
# VGA Planar Memory Read Path

This block returns the byte a CPU read from the 64 KiB graphics window would deliver. Video memory is a four-plane store: each 32-bit word carries one byte per plane. Plane p occupies bits [8p+7:8p]. The caller presents a 17-bit window offset with a one-cycle read strobe, together with the current values of the sequencer memory-mode register and the graphics registers that govern read-back. These are colour compare, plane select, graphics mode and colour don't-care. One cycle later the block presents the read byte, a valid pulse and the current 32-bit latch.

Three addressing schemes are decoded, in fixed priority. Chain-4 maps the offset linearly onto bytes. Odd/even steers even and odd offsets to alternate planes. Planar access loads a whole word into the latch. That word is then read back either as a single selected plane or through a colour-compare reduction that folds all four planes into one byte.

The memory is an internal synchronous RAM with a one-cycle read latency. It has a word write port with per-plane enables, which the write path uses to fill it. Word indices are taken modulo the memory depth.

Top module: `vga_plane_reader`

## Requirements
- R1: While reset is held and in the first cycle after reset, `rd_valid` is 0 and `latch_word` is 0.
- R2: Every cycle with `rd_stb` high produces exactly one cycle with `rd_valid` high, one clock later; strobes on consecutive cycles give results on consecutive cycles. `rd_byte` is never unknown while `rd_valid` is high.
- R3: An offset with bit 16 set returns 0xFF and leaves `latch_word` unchanged.
- R4: When `seq_mem_mode` bit 3 is set (chain-4), the result is byte lane `offset[1:0]` of word `offset[15:2]` (modulo depth). The latch is left unchanged.
- R5: When chain-4 is off and `gfx_mode` bit 4 is set (odd/even), the plane is `{gfx_plane_sel[1], offset[0]}` and the word is `offset[15:1]` (modulo depth). This is the byte address ((offset & ~1) << 1) | plane. The latch is left unchanged.
- R6: Chain-4 takes priority over odd/even when both bits are set.
- R7: With neither mode bit set (planar), the word at `offset[15:0]` (modulo depth) becomes the new `latch_word`, visible in the `rd_valid` cycle.
- R8: In planar mode with `gfx_mode` bit 3 clear, the result is the byte of plane `gfx_plane_sel[1:0]` of the new latch.
- R9: In planar mode with `gfx_mode` bit 3 set, each 4-bit register value is expanded so that bit p fills byte p. The block forms t = (latch XOR expand(`gfx_cmp_color[3:0]`)) AND expand(`gfx_cmp_care[3:0]`), ORs the four bytes of t together and returns the inverse. With no care bits the result is 0xFF.
- R10: A fill writes `fill_data` byte p into word `fill_word` only for planes whose `fill_planes[p]` bit is 1; the other planes keep their content.
- R11: Without planar reads, `latch_word` holds its value across idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read strobe, one cycle per byte read |
| rd_off | input | 17 | Window offset of the read |
| seq_mem_mode | input | 8 | Sequencer memory mode; bit 3 selects chain-4 |
| gfx_cmp_color | input | 8 | Colour compare value, bits [3:0] used |
| gfx_plane_sel | input | 8 | Read plane select, bits [1:0] used |
| gfx_mode | input | 8 | Graphics mode; bit 4 odd/even, bit 3 read mode |
| gfx_cmp_care | input | 8 | Colour don't-care mask, bits [3:0] used |
| fill_en | input | 1 | Memory word write enable |
| fill_word | input | VMEM_AW | Word index for the write |
| fill_data | input | 32 | Word data, byte p for plane p |
| fill_planes | input | 4 | Per-plane write enables |
| rd_valid | output | 1 | Result valid pulse |
| rd_byte | output | 8 | Read result |
| latch_word | output | 32 | Current 32-bit latch |

## Verification
The hardest situation to reach is a latch update that overlaps other activity. Examples are a planar read that immediately follows another planar read, or a chain-4 or out-of-range read whose only visible effect would be a wrongly moved latch. The stimulus issues back-to-back strobes with differing modes and offsets, so each result lands in the cycle right after its predecessor. It then checks both the byte and the latch against a bench-side model of the memory and the latch. The colour-compare case is driven with a latch that was loaded by the same read, and with both all-care and no-care masks.

// File: rtl/vga_rd_pkg.sv
package vga_rd_pkg;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_CHAIN  = 2'd1,
    ACC_ODDEVN = 2'd2,
    ACC_PLANAR = 2'd3
  } acc_kind_t;

  typedef struct packed {
    logic      valid;
    acc_kind_t kind;
    logic [1:0] plane;
    logic      cmp_mode;
    logic [3:0] color;
    logic [3:0] care;
  } rd_stage_t;

  function automatic logic [31:0] widen_nibble(input logic [3:0] n);
    logic [31:0] r;
    for (int p = 0; p < 4; p++) r[p*8 +: 8] = {8{n[p]}};
    return r;
  endfunction

  function automatic logic [7:0] color_fold(input logic [31:0] w,
                                            input logic [3:0] color,
                                            input logic [3:0] care);
    logic [31:0] t;
    t = (w ^ widen_nibble(color)) & widen_nibble(care);
    return ~(t[7:0] | t[15:8] | t[23:16] | t[31:24]);
  endfunction

endpackage

// File: rtl/vga_rd_decode.sv
module vga_rd_decode
  import vga_rd_pkg::*;
#(
  parameter int VMEM_AW = 8
) (
  input  logic [16:0]        off,
  input  logic               chain_on,
  input  logic               oddevn_on,
  input  logic [1:0]         plane_sel,
  output acc_kind_t          kind,
  output logic [VMEM_AW-1:0] word,
  output logic [1:0]         plane
);
  logic [15:0] word16;

  always_comb begin
    kind   = ACC_PLANAR;
    word16 = off[15:0];
    plane  = plane_sel;
    if (off[16]) begin
      kind   = ACC_NONE;
    end else if (chain_on) begin
      kind   = ACC_CHAIN;
      word16 = {2'b00, off[15:2]};
      plane  = off[1:0];
    end else if (oddevn_on) begin
      kind   = ACC_ODDEVN;
      word16 = {1'b0, off[15:1]};
      plane  = {plane_sel[1], off[0]};
    end
  end

  assign word = word16[VMEM_AW-1:0];

endmodule

// File: rtl/vga_vram.sv
module vga_vram #(
  parameter int VMEM_AW = 8,
  parameter int PLANES  = 4
) (
  input  logic                clk,
  input  logic                we,
  input  logic [VMEM_AW-1:0]  waddr,
  input  logic [PLANES*8-1:0] wdata,
  input  logic [PLANES-1:0]   wplanes,
  input  logic                re,
  input  logic [VMEM_AW-1:0]  raddr,
  output logic [PLANES*8-1:0] q
);
  localparam int DEPTH = 1 << VMEM_AW;

  for (genvar p = 0; p < PLANES; p++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (we && wplanes[p]) mem[waddr] <= wdata[p*8 +: 8];
      if (re) lane_q <= mem[raddr];
    end

    assign q[p*8 +: 8] = lane_q;
  end

endmodule

// File: rtl/vga_rd_reduce.sv
module vga_rd_reduce
  import vga_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rd_stage_t st,
  input  logic [31:0] ram_q,
  input  logic [31:0] latch_q,
  output logic [7:0]  byte_out,
  output logic [31:0] latch_next
);
  logic planar_hit;
  assign planar_hit = st.valid && (st.kind == ACC_PLANAR);
  assign latch_next = planar_hit ? ram_q : latch_q;

  always_comb begin
    unique case (st.kind)
      ACC_NONE:   byte_out = 8'hFF;
      ACC_PLANAR: byte_out = st.cmp_mode ? color_fold(ram_q, st.color, st.care)
                                         : ram_q[st.plane*8 +: 8];
      default:    byte_out = ram_q[st.plane*8 +: 8];
    endcase
  end

  // R9: without care bits every compare matches, so the fold is all ones
  p_nocare_ones_r9: assert property (@(posedge clk) disable iff (rst)
    (planar_hit && st.cmp_mode && st.care == 4'h0) |-> byte_out == 8'hFF);

endmodule

// File: rtl/vga_plane_reader.sv
module vga_plane_reader
  import vga_rd_pkg::*;
#(
  parameter int VMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_stb,
  input  logic [16:0]        rd_off,
  input  logic [7:0]         seq_mem_mode,
  input  logic [7:0]         gfx_cmp_color,
  input  logic [7:0]         gfx_plane_sel,
  input  logic [7:0]         gfx_mode,
  input  logic [7:0]         gfx_cmp_care,
  input  logic               fill_en,
  input  logic [VMEM_AW-1:0] fill_word,
  input  logic [31:0]        fill_data,
  input  logic [3:0]         fill_planes,
  output logic               rd_valid,
  output logic [7:0]         rd_byte,
  output logic [31:0]        latch_word
);
  localparam int PLANES = 4;

  acc_kind_t          dec_kind;
  logic [VMEM_AW-1:0] dec_word;
  logic [1:0]         dec_plane;
  logic [31:0]        ram_q;
  logic [31:0]        latch_q;
  logic [31:0]        latch_next;
  rd_stage_t          st;

  logic unused_cfg;
  assign unused_cfg = ^{seq_mem_mode[7:4], seq_mem_mode[2:0], gfx_cmp_color[7:4],
                        gfx_plane_sel[7:2], gfx_mode[7:5], gfx_mode[2:0], gfx_cmp_care[7:4]};

  vga_rd_decode #(.VMEM_AW(VMEM_AW)) u_decode (
    .off       (rd_off),
    .chain_on  (seq_mem_mode[3]),
    .oddevn_on (gfx_mode[4]),
    .plane_sel (gfx_plane_sel[1:0]),
    .kind      (dec_kind),
    .word      (dec_word),
    .plane     (dec_plane)
  );

  vga_vram #(.VMEM_AW(VMEM_AW), .PLANES(PLANES)) u_vram (
    .clk     (clk),
    .we      (fill_en),
    .waddr   (fill_word),
    .wdata   (fill_data),
    .wplanes (fill_planes),
    .re      (rd_stb && dec_kind != ACC_NONE),
    .raddr   (dec_word),
    .q       (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st.valid    <= 1'b0;
      st.kind     <= ACC_NONE;
      st.plane    <= 2'd0;
      st.cmp_mode <= 1'b0;
      st.color    <= 4'd0;
      st.care     <= 4'd0;
      latch_q     <= 32'd0;
    end else begin
      st.valid    <= rd_stb;
      st.kind     <= dec_kind;
      st.plane    <= dec_plane;
      st.cmp_mode <= gfx_mode[3];
      st.color    <= gfx_cmp_color[3:0];
      st.care     <= gfx_cmp_care[3:0];
      latch_q     <= latch_next;
    end
  end

  vga_rd_reduce u_reduce (
    .clk        (clk),
    .rst        (rst),
    .st         (st),
    .ram_q      (ram_q),
    .latch_q    (latch_q),
    .byte_out   (rd_byte),
    .latch_next (latch_next)
  );

  assign rd_valid   = st.valid;
  assign latch_word = latch_next;

  // R3: out-of-window offset answers 0xFF
  p_oor_ff_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_off[16])) |-> rd_byte == 8'hFF);

  // R4, R5, R11: only a planar result may move the latch
  p_latch_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && st.kind == ACC_PLANAR) |-> latch_word == $past(latch_word));

  // R2: a presented result is always defined
  p_byte_known_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$isunknown(rd_byte));

endmodule

// File: tb/test_vga_plane_reader.sv
`timescale 1ns/1ps
module test_vga_plane_reader;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_stb = 1'b0;
  logic [16:0] rd_off = '0;
  logic [7:0] sr4 = '0, gr2 = '0, gr4 = '0, gr5 = '0, gr7 = '0;
  logic fill_en = 1'b0;
  logic [AW-1:0] fill_word = '0;
  logic [31:0] fill_data = '0;
  logic [3:0] fill_planes = '0;
  logic rd_valid;
  logic [7:0] rd_byte;
  logic [31:0] latch_word;

  int checks = 0, errors = 0;
  logic [31:0] model [DEPTH];
  logic [31:0] model_latch = '0;

  always #2.5 clk = ~clk;

  vga_plane_reader #(.VMEM_AW(AW)) i_vga_plane_reader (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_off(rd_off),
    .seq_mem_mode(sr4), .gfx_cmp_color(gr2), .gfx_plane_sel(gr4),
    .gfx_mode(gr5), .gfx_cmp_care(gr7), .fill_en(fill_en),
    .fill_word(fill_word), .fill_data(fill_data), .fill_planes(fill_planes),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .latch_word(latch_word));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int w, input int p);
    return 8'((w * 29 + p * 71 + 19) & 8'hFF);
  endfunction

  function automatic logic [31:0] wide(input logic [3:0] n);
    logic [31:0] r;
    for (int p = 0; p < 4; p++) r[p*8 +: 8] = {8{n[p]}};
    return r;
  endfunction

  // independent expectation per requirement R3..R9
  function automatic logic [7:0] expect_byte(input logic [16:0] off);
    int w, pl;
    logic [31:0] t;
    if (off[16]) return 8'hFF;
    if (sr4[3]) begin
      w = int'(off[15:2]) % DEPTH; pl = int'(off[1:0]);
      return model[w][pl*8 +: 8];
    end
    if (gr5[4]) begin
      w = int'(off[15:1]) % DEPTH; pl = int'({gr4[1], off[0]});
      return model[w][pl*8 +: 8];
    end
    w = int'(off[15:0]) % DEPTH;
    model_latch = model[w];
    if (!gr5[3]) return model_latch[int'(gr4[1:0])*8 +: 8];
    t = (model_latch ^ wide(gr2[3:0])) & wide(gr7[3:0]);
    return ~(t[7:0] | t[15:8] | t[23:16] | t[31:24]);
  endfunction

  task automatic fill(input int w, input logic [31:0] d, input logic [3:0] pm);
    @(negedge clk);
    fill_en = 1'b1; fill_word = AW'(w); fill_data = d; fill_planes = pm;
    for (int p = 0; p < 4; p++) if (pm[p]) model[w][p*8 +: 8] = d[p*8 +: 8];
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [16:0] off);
    logic [7:0] e;
    @(negedge clk);
    rd_stb = 1'b1; rd_off = off;
    e = expect_byte(off);
    @(negedge clk);
    rd_stb = 1'b0;
    check({req, " valid"}, 32'(rd_valid), 32'd1);
    check({req, " byte"}, 32'(rd_byte), 32'(e));
    check({req, " latch"}, latch_word, model_latch);
  endtask

  task automatic set_regs(input logic [7:0] s4, input logic [7:0] g5, input logic [7:0] g4,
                          input logic [7:0] g2, input logic [7:0] g7);
    sr4 = s4; gr5 = g5; gr4 = g4; gr2 = g2; gr7 = g7;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid in reset", 32'(rd_valid), 32'd0);
    check("R1 latch in reset", latch_word, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", 32'(rd_valid), 32'd0);
    check("R1 latch after reset", latch_word, 32'd0);
  endtask

  task automatic t_fill();
    for (int w = 0; w < DEPTH; w++)
      fill(w, {pat(w, 3), pat(w, 2), pat(w, 1), pat(w, 0)}, 4'hF);
    fill(5, 32'hAABBCCDD, 4'b0101);
    set_regs(8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int b = 20; b < 24; b++) rd("R10 partial plane fill", 17'(b));
  endtask

  task automatic t_chain4();
    set_regs(8'h00, 8'h00, 8'h02, 8'h00, 8'h00);
    rd("R7 load latch", 17'h00033);
    set_regs(8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
    rd("R4 chain", 17'h00001);
    rd("R4 chain", 17'h00102);
    rd("R4 chain wrap", 17'h0ABCF);
  endtask

  task automatic t_oddevn();
    set_regs(8'h00, 8'h10, 8'h00, 8'h00, 8'h00);
    rd("R5 oddevn even", 17'h00040);
    rd("R5 oddevn odd", 17'h00041);
    set_regs(8'h00, 8'h10, 8'h02, 8'h00, 8'h00);
    rd("R5 oddevn hi even", 17'h00076);
    rd("R5 oddevn hi odd", 17'h00077);
  endtask

  task automatic t_priority();
    set_regs(8'h08, 8'h10, 8'h02, 8'h00, 8'h00);
    rd("R6 chain over oddevn", 17'h00045);
  endtask

  task automatic t_planar0();
    for (int p = 0; p < 4; p++) begin
      set_regs(8'h00, 8'h00, 8'(p), 8'h00, 8'h00);
      rd("R8 planar plane", 17'(16'h0010 + p * 3));
    end
    rd("R7 planar wrap", 17'h0F1A2);
  endtask

  task automatic t_planar1();
    set_regs(8'h00, 8'h08, 8'h00, 8'h05, 8'h0F);
    rd("R9 compare all care", 17'h00021);
    set_regs(8'h00, 8'h08, 8'h00, 8'h0A, 8'h00);
    rd("R9 compare no care", 17'h00022);
    set_regs(8'h00, 8'h08, 8'h00, 8'h03, 8'h06);
    rd("R9 compare partial", 17'h00005);
  endtask

  task automatic t_oor();
    set_regs(8'h00, 8'h00, 8'h01, 8'h00, 8'h00);
    rd("R7 load before oor", 17'h00099);
    rd("R3 out of window", 17'h10000);
    set_regs(8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
    rd("R3 out of window chain", 17'h1FFFF);
  endtask

  task automatic t_b2b();
    logic [7:0] e1, e2;
    logic [31:0] l1;
    set_regs(8'h00, 8'h00, 8'h03, 8'h00, 8'h00);
    @(negedge clk);
    rd_stb = 1'b1; rd_off = 17'h00011; e1 = expect_byte(17'h00011); l1 = model_latch;
    @(negedge clk);
    rd_off = 17'h00012; e2 = expect_byte(17'h00012);
    check("R2 b2b first valid", 32'(rd_valid), 32'd1);
    check("R2 b2b first byte", 32'(rd_byte), 32'(e1));
    check("R7 b2b first latch", latch_word, l1);
    @(negedge clk);
    rd_stb = 1'b0;
    check("R2 b2b second valid", 32'(rd_valid), 32'd1);
    check("R2 b2b second byte", 32'(rd_byte), 32'(e2));
    check("R7 b2b second latch", latch_word, model_latch);
    @(negedge clk);
    check("R2 single pulse", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    check("R11 latch holds idle", latch_word, model_latch);
    check("R2 no spurious valid", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fill();
        t_chain4();
        t_oddevn();
        t_priority();
        t_planar0();
        t_planar1();
        t_oor();
        t_b2b();
        t_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule